// File: doc/BRIEF.md
# Per-Sprite Pattern Bank Remapper

This block keeps one 16-bit bank number for each sprite slot of the picture unit and uses it to relocate sprite pattern fetches in a large character memory. The CPU loads each bank through two byte-wide write windows. One window carries the high byte of a slot and the other carries the low byte. A write to either window leaves the other byte of that slot as it was.

Each fetch arrives as a request on a valid/ready stream. A request carries the pattern address that the picture unit asked for, the slot index of the sprite being fetched, a flag that marks the sprite pattern fetch phase, and the address that the normal character banking produced. Three plain control pins qualify the request: extended sprite mode, background rendering enabled, and tall (8x16) sprites. When all three conditions hold (extended mode, background enabled, and the request in the sprite fetch phase), the block replaces the address with the slot's bank. The bank is shifted by 12 bits for 8x8 sprites or by 13 bits for 8x16 sprites, and then the pattern address is added. Otherwise the normal address passes through unchanged.

The result leaves through a registered valid/ready output of one entry. A held output blocks new requests: `req_ready` is high only when the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output value does not change.

Top module: `sbt_sprite_bank_map`

## Requirements
- R1: A CPU write to an address in base+0x00 to base+0x3F (base 0x4200) replaces bits 15:8 of the slot named by address bits 5:0. Bits 7:0 of that slot are kept.
- R2: A CPU write to an address in base+0x40 to base+0x7F replaces bits 7:0 of the slot named by address bits 5:0. Bits 15:8 are kept.
- R3: A request accepted with extended mode on, background on, sprite-phase flag set and tall off yields `out_override`=1. It also yields `out_addr` = (bank << 12) + pattern address, where the add carries across bit 12.
- R4: The same request with tall on yields `out_addr` = (bank << 13) + pattern address.
- R5: A request accepted with any of extended mode, background or sprite phase low yields `out_override`=0 and `out_addr` equal to the normal address.
- R6: CPU writes outside both windows (for example at base-1 and base+0x80) change no slot.
- R7: `req_ready` = !`out_valid` || `out_ready`. An accepted request appears on the output in the next cycle. A stalled output holds its address and flag stable.
- R8: Reset empties the output stage. It does not clear the bank table.
- R9: When a write and a request for the same slot happen in the same cycle, the request uses the slot's previous value.
- R10: The bank used is the one whose slot equals `req_sprite` at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| ext_spr_en | input | 1 | Extended sprite mode enable |
| bg_show | input | 1 | Background rendering enabled |
| tall_spr | input | 1 | 8x16 sprite size selected |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Fetch request accepted this cycle |
| req_obj_phase | input | 1 | Request belongs to sprite pattern fetch |
| req_sprite | input | 6 | Slot index of sprite being fetched |
| req_pat_addr | input | 13 | Requested pattern address |
| req_norm_addr | input | 29 | Address from normal character banking |
| out_valid | output | 1 | Output address valid |
| out_ready | input | 1 | Consumer takes output |
| out_addr | output | 29 | Resulting character memory address |
| out_override | output | 1 | Output came from the per-slot bank |

## Verification
The bench builds the block with its defaults: 64 slots, a 13-bit pattern address and a 0x4200 window base. With these values the last slot sits on both window edges, 0x423F and 0x427F. The first addresses outside the windows, 0x41FF and 0x4280, can then be written to show that they are ignored. The full 16-bit bank width lets bank 0xFFFF with an 8x16 shift reach the top bit of the 29-bit output. A cycle model written as arrays and integers follows every clock. It covers stalls of several cycles, a write and a request to the same slot in one cycle, and a reset while an output is held.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  localparam int BYTE_W = 8;
  localparam int BANK_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    LANE_NONE = 2'd0,
    LANE_HI   = 2'd1,
    LANE_LO   = 2'd2
  } lane_e;
endpackage

// File: rtl/sbt_wr_decode.sv
module sbt_wr_decode
  import sbt_pkg::*;
#(
  parameter int          N_SPR    = 64,
  parameter int          CPU_AW   = 16,
  parameter int unsigned WIN_BASE = 'h4200
) (
  input  logic                     cpu_we,
  input  logic [CPU_AW-1:0]        cpu_addr,
  output lane_e                    wr_lane,
  output logic [$clog2(N_SPR)-1:0] wr_idx
);
  localparam int IDX_W = $clog2(N_SPR);
  localparam int SPAN  = 2 * N_SPR;

  logic [CPU_AW-1:0] offs;
  logic              in_win;

  assign offs   = cpu_addr - CPU_AW'(WIN_BASE);
  assign in_win = cpu_we && (cpu_addr >= CPU_AW'(WIN_BASE)) && (offs < CPU_AW'(SPAN));
  assign wr_idx = offs[IDX_W-1:0];

  // offset bit IDX_W separates the high-byte half from the low-byte half
  always_comb begin
    wr_lane = LANE_NONE;
    if (in_win) wr_lane = offs[IDX_W] ? LANE_LO : LANE_HI;
  end
endmodule

// File: rtl/sbt_bank_regs.sv
module sbt_bank_regs
  import sbt_pkg::*;
#(
  parameter int N_SPR = 64
) (
  input  logic                     clk,
  input  lane_e                    wr_lane,
  input  logic [$clog2(N_SPR)-1:0] wr_idx,
  input  logic [BYTE_W-1:0]        wr_data,
  input  logic [$clog2(N_SPR)-1:0] rd_idx,
  output logic [BANK_W-1:0]        rd_bank
);
  localparam int IDX_W = $clog2(N_SPR);

  logic [N_SPR-1:0][BANK_W-1:0] ents;

  // contents deliberately survive reset
  for (genvar g = 0; g < N_SPR; g++) begin : g_slot
    logic [BYTE_W-1:0] hi_q;
    logic [BYTE_W-1:0] lo_q;
    logic              hit;

    assign hit = (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (hit && wr_lane == LANE_HI) hi_q <= wr_data;
      if (hit && wr_lane == LANE_LO) lo_q <= wr_data;
    end

    assign ents[g] = {hi_q, lo_q};
  end

  assign rd_bank = ents[rd_idx];
endmodule

// File: rtl/sbt_addr_gen.sv
module sbt_addr_gen
  import sbt_pkg::*;
#(
  parameter int PAT_W = 13
) (
  input  logic                    ext_en,
  input  logic                    bg_on,
  input  logic                    obj_phase,
  input  logic                    tall,
  input  logic [BANK_W-1:0]       bank,
  input  logic [PAT_W-1:0]        pat_addr,
  input  logic [BANK_W+PAT_W-1:0] norm_addr,
  output logic [BANK_W+PAT_W-1:0] addr,
  output logic                    override
);
  localparam int OUT_W = BANK_W + PAT_W;

  logic [OUT_W-1:0] base_w;
  logic [OUT_W-1:0] shifted;
  logic [OUT_W-1:0] remapped;

  assign base_w   = OUT_W'(bank);
  assign shifted  = tall ? (base_w << PAT_W) : (base_w << (PAT_W - 1));
  assign remapped = shifted + OUT_W'(pat_addr);
  assign override = ext_en && bg_on && obj_phase;
  assign addr     = override ? remapped : norm_addr;
endmodule

// File: rtl/sbt_out_stage.sv
module sbt_out_stage #(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         v_q;
  logic [W-1:0] d_q;

  assign in_ready  = !v_q || out_ready;
  assign out_valid = v_q;
  assign out_data  = d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) v_q <= 1'b0;
    else if (in_ready) v_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) d_q <= in_data;
  end
endmodule

// File: rtl/sbt_sprite_bank_map.sv
module sbt_sprite_bank_map
  import sbt_pkg::*;
#(
  parameter int          N_SPR    = 64,
  parameter int          PAT_W    = 13,
  parameter int          CPU_AW   = 16,
  parameter int unsigned WIN_BASE = 'h4200
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cpu_we,
  input  logic [CPU_AW-1:0]           cpu_addr,
  input  logic [7:0]                  cpu_wdata,
  input  logic                        ext_spr_en,
  input  logic                        bg_show,
  input  logic                        tall_spr,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_obj_phase,
  input  logic [$clog2(N_SPR)-1:0]    req_sprite,
  input  logic [PAT_W-1:0]            req_pat_addr,
  input  logic [2*8+PAT_W-1:0]        req_norm_addr,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [2*8+PAT_W-1:0]        out_addr,
  output logic                        out_override
);
  localparam int IDX_W = $clog2(N_SPR);
  localparam int OUT_W = BANK_W + PAT_W;

  lane_e             wr_lane;
  logic [IDX_W-1:0]  wr_idx;
  logic [BANK_W-1:0] sel_bank;
  logic [OUT_W-1:0]  nxt_addr;
  logic              nxt_ovr;

  sbt_wr_decode #(.N_SPR(N_SPR), .CPU_AW(CPU_AW), .WIN_BASE(WIN_BASE)) u_dec (
    .cpu_we  (cpu_we),
    .cpu_addr(cpu_addr),
    .wr_lane (wr_lane),
    .wr_idx  (wr_idx)
  );

  sbt_bank_regs #(.N_SPR(N_SPR)) u_regs (
    .clk    (clk),
    .wr_lane(wr_lane),
    .wr_idx (wr_idx),
    .wr_data(cpu_wdata),
    .rd_idx (req_sprite),
    .rd_bank(sel_bank)
  );

  sbt_addr_gen #(.PAT_W(PAT_W)) u_gen (
    .ext_en   (ext_spr_en),
    .bg_on    (bg_show),
    .obj_phase(req_obj_phase),
    .tall     (tall_spr),
    .bank     (sel_bank),
    .pat_addr (req_pat_addr),
    .norm_addr(req_norm_addr),
    .addr     (nxt_addr),
    .override (nxt_ovr)
  );

  sbt_out_stage #(.W(OUT_W + 1)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_ready (req_ready),
    .in_data  ({nxt_ovr, nxt_addr}),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data ({out_override, out_addr})
  );
endmodule

// File: rtl/sbt_sprite_bank_map_chk.sv
module sbt_sprite_bank_map_chk #(
  parameter int N_SPR = 64,
  parameter int PAT_W = 13
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ext_spr_en,
  input logic                 bg_show,
  input logic                 tall_spr,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_obj_phase,
  input logic [PAT_W-1:0]     req_pat_addr,
  input logic [16+PAT_W-1:0]  req_norm_addr,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [16+PAT_W-1:0]  out_addr,
  input logic                 out_override
);
  logic take;
  logic remap;
  assign take  = req_valid && req_ready;
  assign remap = ext_spr_en && bg_show && req_obj_phase;

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_override));

  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !req_ready);

  // R7
  accept_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R3
  short_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && remap && !tall_spr |=>
      out_override && out_addr[PAT_W-2:0] == $past(req_pat_addr[PAT_W-2:0]));

  // R4
  tall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && remap && tall_spr |=> out_override && out_addr[PAT_W-1:0] == $past(req_pat_addr));

  // R5
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !remap |=> !out_override && out_addr == $past(req_norm_addr));

  // R8
  reset_empty_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);
endmodule

bind sbt_sprite_bank_map sbt_sprite_bank_map_chk #(.N_SPR(N_SPR), .PAT_W(PAT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ext_spr_en   (ext_spr_en),
  .bg_show      (bg_show),
  .tall_spr     (tall_spr),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_obj_phase(req_obj_phase),
  .req_pat_addr (req_pat_addr),
  .req_norm_addr(req_norm_addr),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_addr     (out_addr),
  .out_override (out_override)
);

// File: tb/sbt_sprite_bank_map_tb.sv
module sbt_sprite_bank_map_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        ext_spr_en = 1'b0, bg_show = 1'b0, tall_spr = 1'b0;
  logic        req_valid = 1'b0, req_obj_phase = 1'b0;
  logic        req_ready;
  logic [5:0]  req_sprite = '0;
  logic [12:0] req_pat_addr = '0;
  logic [28:0] req_norm_addr = '0;
  logic        out_valid, out_ready = 1'b1, out_override;
  logic [28:0] out_addr;

  int     checks = 0, errors = 0;
  string  phase_tag = "R8";
  int     mbank [64];
  bit     m_valid = 0, m_ovr = 0;
  longint m_addr = 0;
  string  m_tag = "R5";

  always #4 clk = ~clk;

  sbt_sprite_bank_map u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .ext_spr_en(ext_spr_en), .bg_show(bg_show), .tall_spr(tall_spr),
    .req_valid(req_valid), .req_ready(req_ready), .req_obj_phase(req_obj_phase),
    .req_sprite(req_sprite), .req_pat_addr(req_pat_addr), .req_norm_addr(req_norm_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_override(out_override)
  );

  task automatic chk(bit ok, string rq, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) actual %0h expected %0h at %0t", rq, phase_tag, act, exp, $time);
    end
  endtask

  // reference: request sees the table before the same-cycle write (R9)
  task automatic model();
    bit ovr;
    int a;
    if (!rst_n) m_valid = 0;
    else if (req_valid && (!m_valid || out_ready)) begin
      ovr = ext_spr_en && bg_show && req_obj_phase;
      m_ovr = ovr;
      m_valid = 1;
      if (ovr) begin
        m_tag  = tall_spr ? "R4" : "R3";
        m_addr = (longint'(mbank[req_sprite]) << (tall_spr ? 13 : 12)) + longint'(req_pat_addr);
      end else begin
        m_tag  = "R5";
        m_addr = longint'(req_norm_addr);
      end
    end else if (out_ready) m_valid = 0;
    if (cpu_we) begin
      a = int'(cpu_addr);
      if (a >= 'h4200 && a <= 'h423F) mbank[a & 63] = (mbank[a & 63] & 'hFF) | (int'(cpu_wdata) << 8);
      else if (a >= 'h4240 && a <= 'h427F) mbank[a & 63] = (mbank[a & 63] & 'hFF00) | int'(cpu_wdata);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model();
    @(negedge clk);
    chk(out_valid == m_valid, "R7", longint'(out_valid), longint'(m_valid));
    chk(req_ready == (!m_valid || out_ready), "R7", longint'(req_ready), longint'(!m_valid || out_ready));
    if (m_valid && out_valid) begin
      chk(out_override == m_ovr, m_tag, longint'(out_override), longint'(m_ovr));
      chk(longint'(out_addr) == m_addr, m_tag, longint'(out_addr), m_addr);
    end
  endtask

  task automatic wr(int a, int d);
    cpu_we = 1; cpu_addr = 16'(a); cpu_wdata = 8'(d);
    step();
    cpu_we = 0;
  endtask

  task automatic rq(int s, int p, int n);
    req_valid = 1; req_sprite = 6'(s); req_pat_addr = 13'(p); req_norm_addr = 29'(n);
    step();
    req_valid = 0;
    step();
  endtask

  task automatic mode(bit e, bit b, bit o, bit t);
    ext_spr_en = e; bg_show = b; req_obj_phase = o; tall_spr = t;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mbank[i] = 0;
    // R8 reset state
    step(); step();
    rst_n = 1;
    step();

    // R1 R2 load every slot through both windows
    phase_tag = "R1";
    for (int i = 0; i < 64; i++) wr('h4200 + i, (i * 37 + 11) & 255);
    phase_tag = "R2";
    for (int i = 0; i < 64; i++) wr('h4240 + i, (i * 91 + 3) & 255);

    // R10 R3 short sprites, carry across bit 12
    phase_tag = "R10";
    mode(1, 1, 1, 0);
    for (int i = 0; i < 64; i += 7) rq(i, (i * 401) & 'h1FFF, 'h123);
    rq(5, 'h1ABC, 0);
    // R4 tall sprites
    mode(1, 1, 1, 1);
    for (int i = 3; i < 64; i += 9) rq(i, (i * 733) & 'h1FFF, 0);

    // R5 each gating condition low
    phase_tag = "R5";
    mode(0, 1, 1, 0); rq(10, 'h0456, 'h1234567);
    mode(1, 0, 1, 1); rq(11, 'h0FFF, 'h0ABCDEF);
    mode(1, 1, 0, 0); rq(12, 'h1000, 'h1FFFFFFF);

    // R1 only upper byte replaced; R2 only lower byte replaced
    mode(1, 1, 1, 0);
    phase_tag = "R1";
    wr('h4205, 'hC3); rq(5, 'h0010, 0);
    phase_tag = "R2";
    wr('h4245, 'h5A); rq(5, 'h0020, 0);

    // R6 writes just outside both windows
    phase_tag = "R6";
    wr('h41FF, 'h77); wr('h4280, 'h66); wr('h4300, 'h55);
    rq(63, 'h0001, 0); rq(0, 'h0002, 0);

    // R4 top bank, top pattern address, window edges
    phase_tag = "R4";
    wr('h423F, 'hFF); wr('h427F, 'hFF);
    mode(1, 1, 1, 1); rq(63, 'h1FFF, 0);

    // R9 write and request of the same slot in one cycle
    phase_tag = "R9";
    mode(1, 1, 1, 0);
    cpu_we = 1; cpu_addr = 16'h4207; cpu_wdata = 8'h99;
    req_valid = 1; req_sprite = 6'd7; req_pat_addr = 13'h0033;
    step();
    cpu_we = 0; req_valid = 0;
    step();
    rq(7, 'h0044, 0);

    // R7 back-pressure: stall for several cycles
    phase_tag = "R7";
    out_ready = 0;
    req_valid = 1; req_sprite = 6'd20; req_pat_addr = 13'h0101;
    step();
    req_sprite = 6'd21; req_pat_addr = 13'h0202;
    step(); step(); step();
    out_ready = 1;
    step();
    step();
    req_valid = 0;
    step(); step();

    // R8 reset while output held; table survives
    phase_tag = "R8";
    out_ready = 0;
    req_valid = 1; req_sprite = 6'd30;
    step();
    req_valid = 0;
    rst_n = 0;
    step(); step();
    rst_n = 1; out_ready = 1;
    step();
    rq(30, 'h0808, 0);
    rq(62, 'h0909, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule